// File: doc/BRIEF.md
# Variable-Length Network Header Parser

This block takes one network packet at a time as a stream of 16-bit words. The first word is marked as start and the last as end. The first word is a fixed base header. The addressing-mode bits in the base word, plus a saturated hop count, decide which optional 16-bit words follow it. The parser records each field of the header, reports which optional fields were present and issues a strobe once the whole header is in. Every word after the header is forwarded as payload, and the parser counts its bytes.

A closing strobe reports the payload byte count and two error flags. One flag marks a stream that ended before the header was complete. The other marks a payload longer than the configured limit. Any address missing from a header reads as zero, which is the master node. Acting on the command code and making routing decisions belong to the blocks downstream.

Top module: `net_hdr_parser`

## Requirements
- R1: The base word (first word, start marker high) is decoded from MSB to LSB as hop count [15:11], direction [10], addressing mode [9:8], sequence [7:4], command code [3:1] and layer flag [0], and these values are presented when the header-done strobe is issued.
- R2: The optional words that follow the base word appear only in this order: hop extension when the hop field is 31, then source address when the mode is 0 or 1, then destination address when the mode is 1, 2 or 3, then three hardware-address words (most significant first) and a depth word when the mode is 3.
- R3: When a field is absent its value reads 0: source, destination, the 48-bit hardware address and depth. The present flags for source, destination, hardware address (together with depth) and hop extension match the rule in R2.
- R4: The reported hop count is the 5-bit field zero-extended. When the field is 31 the reported count is 31 plus the extension word, on 17 bits.
- R5: Header-done is a one-cycle pulse in the cycle after the last header word is accepted. The decoded fields keep their values until the next start marker.
- R6: Payload words come out one cycle after they are accepted, with an end flag on the last word and a half flag when that last word carries only its upper byte. Header words never appear on the payload output.
- R7: A packet-done pulse appears in the cycle after the end marker. At that time the byte count equals two per payload word, minus one if the final word is marked half. A header with no payload gives a count of 0.
- R8: If the end marker arrives before every required header word, including on the base word itself, packet-done is issued with the truncation error set and no header-done is issued.
- R9: If the payload exceeds MAX_PAYLOAD bytes, the oversize error is set with packet-done and the count saturates at MAX_PAYLOAD+1. Exactly MAX_PAYLOAD bytes raises no error.
- R10: A start marker always begins a new packet and drops any packet still open. Valid words that arrive while no packet is open have no effect on any output.
- R11: After reset, all strobes, payload outputs and decoded fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Word is the base header word |
| in_eop | input | 1 | Word is the last of the packet |
| in_half | input | 1 | With in_eop: only the upper byte is used |
| in_data | input | 16 | Input word |
| hdr_done | output | 1 | Header complete strobe |
| hops_val | output | 17 | Hop count, extended when saturated |
| dir_flag | output | 1 | Direction bit |
| addr_mode | output | 2 | Addressing mode |
| seq_num | output | 4 | Sequence number |
| cmd_code | output | 3 | Command code |
| layer_flag | output | 1 | Network/application layer selector |
| src_addr | output | 16 | Source address, 0 when absent |
| dst_addr | output | 16 | Destination address, 0 when absent |
| hw_addr | output | 48 | Hardware address, 0 when absent |
| depth_val | output | 16 | Target depth, 0 when absent |
| ext_present | output | 1 | Hop extension word was present |
| src_present | output | 1 | Source word was present |
| dst_present | output | 1 | Destination word was present |
| hw_present | output | 1 | Hardware address and depth were present |
| pl_valid | output | 1 | Payload word valid |
| pl_data | output | 16 | Payload word |
| pl_last | output | 1 | Last payload word |
| pl_half | output | 1 | Last payload word holds one byte |
| pkt_done | output | 1 | Packet closed strobe |
| pl_bytes | output | 5 | Payload byte count (width derived from MAX_PAYLOAD) |
| err_trunc | output | 1 | Header cut short |
| err_oversize | output | 1 | Payload above limit |

## Verification
The bench builds the parser with MAX_PAYLOAD set to 16 instead of 240. With that limit, both the oversize error and the saturated count can be reached with packets of eight and nine payload words, so the boundary on either side of the limit gets checked without long streams. The other parameters keep their defaults, so the base-word layout, the hop-extension threshold of 31 and the 48-bit hardware address are checked at their real widths. The Ports table lists pl_bytes at the width that this bench build produces.

// File: rtl/nhp_pkg.sv
// Package: shared widths, the base-word layout and the rule that
// selects the optional header words. Assumes 16-bit stream words.
package nhp_pkg;
    localparam int WORD_W     = 16;
    localparam int HOPS_W     = 5;
    localparam int AM_W       = 2;
    localparam int SEQ_W      = 4;
    localparam int CODE_W     = 3;
    localparam int OPT_N      = 7;
    localparam int HW_WORDS   = 3;
    localparam int HW_W       = HW_WORDS * WORD_W;
    localparam int HOPS_OUT_W = WORD_W + 1;
    localparam int HOPS_SAT   = (1 << HOPS_W) - 1;

    // Optional word slots; the lowest set bit is always consumed first.
    localparam int OPT_EXT   = 0;
    localparam int OPT_SRC   = 1;
    localparam int OPT_DST   = 2;
    localparam int OPT_HW0   = 3;
    localparam int OPT_DEPTH = OPT_HW0 + HW_WORDS;

    typedef struct packed {
        logic [HOPS_W-1:0] hops;
        logic              dir;
        logic [AM_W-1:0]   am;
        logic [SEQ_W-1:0]  seq;
        logic [CODE_W-1:0] code;
        logic              layer;
    } base_t;

    // Which optional words a given base word asks for.
    function automatic logic [OPT_N-1:0] opt_mask(base_t b);
        logic [OPT_N-1:0] m;
        m          = '0;
        m[OPT_EXT] = (b.hops == HOPS_W'(HOPS_SAT));
        m[OPT_SRC] = (b.am < 2'd2);
        m[OPT_DST] = (b.am > 2'd0);
        for (int i = OPT_HW0; i <= OPT_DEPTH; i++) m[i] = (b.am == 2'd3);
        return m;
    endfunction
endpackage

// File: rtl/nhp_word_sched.sv
// Word scheduler: tracks whether a packet is open and which optional
// header words are still owed, and classifies every input beat.
// Assumes a start marker may arrive at any time and restarts parsing.
module nhp_word_sched
    import nhp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    output logic              start,
    output logic              hdr_beat,
    output logic              pay_beat,
    output logic [OPT_N-1:0]  sel,
    output logic [OPT_N-1:0]  start_mask,
    output logic              hdr_fin,
    output logic              trunc,
    output logic              close
);
    logic             busy;
    logic [OPT_N-1:0] pend;
    logic [OPT_N-1:0] rest;

    // Classify the current beat and pick the optional slot it fills.
    always_comb begin
        start      = in_valid && in_sop;
        start_mask = opt_mask(base_t'(in_data));
        hdr_beat   = in_valid && !in_sop && busy && (pend != '0);
        pay_beat   = in_valid && !in_sop && busy && (pend == '0);
        sel        = hdr_beat ? (pend & (~pend + OPT_N'(1))) : '0;
        rest       = pend & ~sel;
        hdr_fin    = hdr_beat && (rest == '0);
        trunc      = in_valid && in_eop && (start || (hdr_beat && !hdr_fin));
        close      = in_valid && in_eop && (start || busy);
    end

    // Open/close the packet and retire owed header words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pend <= '0;
        end else if (start) begin
            busy <= !in_eop;
            pend <= start_mask;
        end else if (in_valid && busy) begin
            if (hdr_beat) pend <= rest;
            if (in_eop)   busy <= 1'b0;
        end
    end
endmodule

// File: rtl/nhp_field_capture.sv
// Field capture: registers the base-word fields and every optional
// word into its slot, clearing absent ones to zero at each start.
// Assumes sel is one-hot or zero and only active on header beats.
module nhp_field_capture
    import nhp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  hdr_fin,
    input  logic [OPT_N-1:0]      sel,
    input  logic [OPT_N-1:0]      start_mask,
    input  logic [WORD_W-1:0]     in_data,
    output logic                  hdr_done,
    output logic [HOPS_OUT_W-1:0] hops_val,
    output logic                  dir_flag,
    output logic [AM_W-1:0]       addr_mode,
    output logic [SEQ_W-1:0]      seq_num,
    output logic [CODE_W-1:0]     cmd_code,
    output logic                  layer_flag,
    output logic [WORD_W-1:0]     src_addr,
    output logic [WORD_W-1:0]     dst_addr,
    output logic [HW_W-1:0]       hw_addr,
    output logic [WORD_W-1:0]     depth_val,
    output logic                  ext_present,
    output logic                  src_present,
    output logic                  dst_present,
    output logic                  hw_present
);
    base_t b;
    assign b = base_t'(in_data);

    // Base fields, presence flags and the hop count (extended on demand).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hops_val    <= '0;
            dir_flag    <= 1'b0;
            addr_mode   <= '0;
            seq_num     <= '0;
            cmd_code    <= '0;
            layer_flag  <= 1'b0;
            ext_present <= 1'b0;
            src_present <= 1'b0;
            dst_present <= 1'b0;
            hw_present  <= 1'b0;
        end else if (start) begin
            hops_val    <= HOPS_OUT_W'(b.hops);
            dir_flag    <= b.dir;
            addr_mode   <= b.am;
            seq_num     <= b.seq;
            cmd_code    <= b.code;
            layer_flag  <= b.layer;
            ext_present <= start_mask[OPT_EXT];
            src_present <= start_mask[OPT_SRC];
            dst_present <= start_mask[OPT_DST];
            hw_present  <= start_mask[OPT_HW0];
        end else if (sel[OPT_EXT]) begin
            hops_val    <= HOPS_OUT_W'(in_data) + HOPS_OUT_W'(HOPS_SAT);
        end
    end

    // One register per single-word optional slot, cleared at start.
    logic [WORD_W-1:0] slot_q [OPT_SRC:OPT_DEPTH];
    genvar g;
    generate
        for (g = OPT_SRC; g <= OPT_DEPTH; g++) begin : g_slot
            // Capture slot g when the scheduler selects it.
            always_ff @(posedge clk) begin
                if (!rst_n || start) slot_q[g] <= '0;
                else if (sel[g])     slot_q[g] <= in_data;
            end
        end
        for (g = 0; g < HW_WORDS; g++) begin : g_hw
            assign hw_addr[HW_W-1-g*WORD_W -: WORD_W] = slot_q[OPT_HW0+g];
        end
    endgenerate

    assign src_addr  = slot_q[OPT_SRC];
    assign dst_addr  = slot_q[OPT_DST];
    assign depth_val = slot_q[OPT_DEPTH];

    // Header-done strobe, one cycle after the last header word.
    always_ff @(posedge clk) begin
        if (!rst_n) hdr_done <= 1'b0;
        else        hdr_done <= hdr_fin;
    end
endmodule

// File: rtl/nhp_payload_track.sv
// Payload tracker: forwards payload words one cycle late, counts bytes
// with saturation at MAX_PAYLOAD+1 and raises the closing strobe and
// error flags. Assumes in_half only matters on the end-marked word.
module nhp_payload_track
    import nhp_pkg::*;
#(
    parameter int MAX_PAYLOAD = 240,
    localparam int CNT_W = $clog2(MAX_PAYLOAD + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pay_beat,
    input  logic              trunc,
    input  logic              close,
    input  logic              in_eop,
    input  logic              in_half,
    input  logic [WORD_W-1:0] in_data,
    output logic              pl_valid,
    output logic [WORD_W-1:0] pl_data,
    output logic              pl_last,
    output logic              pl_half,
    output logic              pkt_done,
    output logic [CNT_W-1:0]  pl_bytes,
    output logic              err_trunc,
    output logic              err_oversize
);
    localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(MAX_PAYLOAD + 1);
    localparam logic [CNT_W:0] MAXB  = (CNT_W+1)'(MAX_PAYLOAD);

    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   sum;
    logic [CNT_W:0]   cnt_nxt;

    // Next byte count: reset on start, saturating add on payload beats.
    always_comb begin
        sum = {1'b0, count} + ((in_eop && in_half) ? (CNT_W+1)'(1) : (CNT_W+1)'(2));
        if (start)         cnt_nxt = '0;
        else if (pay_beat) cnt_nxt = (sum > LIMIT) ? LIMIT : sum;
        else               cnt_nxt = {1'b0, count};
    end

    // Byte counter and closing strobe with its error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= '0;
            pkt_done     <= 1'b0;
            err_trunc    <= 1'b0;
            err_oversize <= 1'b0;
        end else begin
            count        <= cnt_nxt[CNT_W-1:0];
            pkt_done     <= close;
            err_trunc    <= trunc;
            err_oversize <= close && !trunc && (cnt_nxt > MAXB);
        end
    end

    // Payload word forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_valid <= 1'b0;
            pl_data  <= '0;
            pl_last  <= 1'b0;
            pl_half  <= 1'b0;
        end else begin
            pl_valid <= pay_beat;
            pl_data  <= pay_beat ? in_data : '0;
            pl_last  <= pay_beat && in_eop;
            pl_half  <= pay_beat && in_eop && in_half;
        end
    end

    assign pl_bytes = count;
endmodule

// File: rtl/net_hdr_parser.sv
// Top: variable-length network header parser. Splits each packet into
// decoded header fields and a counted payload stream.
// Assumes one packet at a time, words framed by start/end markers.
module net_hdr_parser
    import nhp_pkg::*;
#(
    parameter int MAX_PAYLOAD = 240,
    localparam int CNT_W = $clog2(MAX_PAYLOAD + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic                  in_half,
    input  logic [WORD_W-1:0]     in_data,
    output logic                  hdr_done,
    output logic [HOPS_OUT_W-1:0] hops_val,
    output logic                  dir_flag,
    output logic [AM_W-1:0]       addr_mode,
    output logic [SEQ_W-1:0]      seq_num,
    output logic [CODE_W-1:0]     cmd_code,
    output logic                  layer_flag,
    output logic [WORD_W-1:0]     src_addr,
    output logic [WORD_W-1:0]     dst_addr,
    output logic [HW_W-1:0]       hw_addr,
    output logic [WORD_W-1:0]     depth_val,
    output logic                  ext_present,
    output logic                  src_present,
    output logic                  dst_present,
    output logic                  hw_present,
    output logic                  pl_valid,
    output logic [WORD_W-1:0]     pl_data,
    output logic                  pl_last,
    output logic                  pl_half,
    output logic                  pkt_done,
    output logic [CNT_W-1:0]      pl_bytes,
    output logic                  err_trunc,
    output logic                  err_oversize
);
    logic             start, hdr_beat, pay_beat, hdr_fin, trunc, close;
    logic [OPT_N-1:0] sel, start_mask;

    nhp_word_sched u_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .start(start),
        .hdr_beat(hdr_beat), .pay_beat(pay_beat), .sel(sel),
        .start_mask(start_mask), .hdr_fin(hdr_fin), .trunc(trunc),
        .close(close)
    );

    nhp_field_capture u_fields (
        .clk(clk), .rst_n(rst_n), .start(start), .hdr_fin(hdr_fin),
        .sel(sel), .start_mask(start_mask), .in_data(in_data),
        .hdr_done(hdr_done), .hops_val(hops_val), .dir_flag(dir_flag),
        .addr_mode(addr_mode), .seq_num(seq_num), .cmd_code(cmd_code),
        .layer_flag(layer_flag), .src_addr(src_addr), .dst_addr(dst_addr),
        .hw_addr(hw_addr), .depth_val(depth_val),
        .ext_present(ext_present), .src_present(src_present),
        .dst_present(dst_present), .hw_present(hw_present)
    );

    nhp_payload_track #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_payload (
        .clk(clk), .rst_n(rst_n), .start(start), .pay_beat(pay_beat),
        .trunc(trunc), .close(close), .in_eop(in_eop), .in_half(in_half),
        .in_data(in_data), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_last(pl_last), .pl_half(pl_half), .pkt_done(pkt_done),
        .pl_bytes(pl_bytes), .err_trunc(err_trunc),
        .err_oversize(err_oversize)
    );
endmodule

// File: rtl/net_hdr_parser_checks.sv
// Checker: temporal properties on the parser's ports, bound to the top.
module net_hdr_parser_checks
    import nhp_pkg::*;
#(
    parameter int MAX_PAYLOAD = 240,
    localparam int CNT_W = $clog2(MAX_PAYLOAD + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_done,
    input logic [AM_W-1:0]   addr_mode,
    input logic [WORD_W-1:0] src_addr,
    input logic [WORD_W-1:0] dst_addr,
    input logic [HW_W-1:0]   hw_addr,
    input logic              src_present,
    input logic              dst_present,
    input logic              hw_present,
    input logic              pl_valid,
    input logic              pl_last,
    input logic              pl_half,
    input logic              pkt_done,
    input logic [CNT_W-1:0]  pl_bytes,
    input logic              err_trunc,
    input logic              err_oversize
);
    // R3: an absent source reads as the master address
    assert_src_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !src_present) |-> (src_addr == '0));
    // R3: an absent destination reads as the master address
    assert_dst_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !dst_present) |-> (dst_addr == '0));
    // R3: no hardware address reported without its words
    assert_hw_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !hw_present) |-> (hw_addr == '0));
    // R2: presence flags agree with the addressing mode
    assert_presence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> (src_present == (addr_mode < 2'd2)) && (dst_present == (addr_mode != 2'd0)));
    // R5: header-done is a single-cycle pulse
    assert_hdr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> !hdr_done);
    // R6: the half flag only rides on the last payload word
    assert_half_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pl_half |-> (pl_valid && pl_last));
    // R8: truncation error appears only with packet-done and no header-done
    assert_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_trunc |-> (pkt_done && !hdr_done && !err_oversize));
    // R9: oversize reports the saturated count
    assert_oversize_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_oversize |-> (pkt_done && pl_bytes == CNT_W'(MAX_PAYLOAD + 1)));
    // R9: an accepted packet never reports more than the limit
    assert_within_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !err_oversize) |-> (pl_bytes <= CNT_W'(MAX_PAYLOAD)));
endmodule

bind net_hdr_parser net_hdr_parser_checks #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_checks (
    .clk(clk), .rst_n(rst_n), .hdr_done(hdr_done), .addr_mode(addr_mode),
    .src_addr(src_addr), .dst_addr(dst_addr), .hw_addr(hw_addr),
    .src_present(src_present), .dst_present(dst_present),
    .hw_present(hw_present), .pl_valid(pl_valid), .pl_last(pl_last),
    .pl_half(pl_half), .pkt_done(pkt_done), .pl_bytes(pl_bytes),
    .err_trunc(err_trunc), .err_oversize(err_oversize)
);

// File: tb/net_hdr_parser_bench.sv
`timescale 1ns/1ps
module net_hdr_parser_bench;
    localparam int MAXP  = 16;
    localparam int CNT_W = $clog2(MAXP + 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_half = 1'b0;
    logic [15:0] in_data = '0;
    logic        hdr_done, dir_flag, layer_flag;
    logic [16:0] hops_val;
    logic [1:0]  addr_mode;
    logic [3:0]  seq_num;
    logic [2:0]  cmd_code;
    logic [15:0] src_addr, dst_addr, depth_val, pl_data;
    logic [47:0] hw_addr;
    logic        ext_present, src_present, dst_present, hw_present;
    logic        pl_valid, pl_last, pl_half, pkt_done, err_trunc, err_oversize;
    logic [CNT_W-1:0] pl_bytes;

    always #2.5 clk = ~clk;

    net_hdr_parser #(.MAX_PAYLOAD(MAXP)) u_net_hdr_parser (.*);

    int checks = 0, fails = 0;
    bit finished = 0;

    // Monitor captures, sampled on the falling edge.
    int          hdr_cnt, pl_cnt, pkt_cnt;
    logic [63:0] c_hops, c_dir, c_am, c_seq, c_code, c_t, c_src, c_dst, c_hw, c_dep;
    logic [63:0] c_ep, c_sp, c_dp, c_hp, c_bytes, c_tr, c_ov, c_half;
    logic [15:0] pl_buf [0:31];
    logic [15:0] pw [0:31];

    always @(negedge clk) begin
        if (hdr_done) begin
            hdr_cnt++;
            c_hops = 64'(hops_val); c_dir = 64'(dir_flag); c_am = 64'(addr_mode);
            c_seq = 64'(seq_num); c_code = 64'(cmd_code); c_t = 64'(layer_flag);
            c_src = 64'(src_addr); c_dst = 64'(dst_addr); c_hw = 64'(hw_addr);
            c_dep = 64'(depth_val); c_ep = 64'(ext_present); c_sp = 64'(src_present);
            c_dp = 64'(dst_present); c_hp = 64'(hw_present);
        end
        if (pl_valid) begin
            if (pl_cnt < 32) pl_buf[pl_cnt] = pl_data;
            pl_cnt++;
            if (pl_last) c_half = 64'(pl_half);
        end
        if (pkt_done) begin
            pkt_cnt++;
            c_bytes = 64'(pl_bytes); c_tr = 64'(err_trunc); c_ov = 64'(err_oversize);
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int hops, input int d, input int am,
                                       input int sq, input int code, input int t);
        return {5'(hops), 1'(d), 2'(am), 4'(sq), 3'(code), 1'(t)};
    endfunction

    task automatic clear_mon();
        hdr_cnt = 0; pl_cnt = 0; pkt_cnt = 0; c_half = 0;
    endtask

    // Drive pw[0..n-1] as one packet; half marks the final word.
    task automatic send(input int n, input bit sop_first, input bit eop_last, input bit half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = sop_first && (i == 0);
            in_eop   = eop_last && (i == n - 1);
            in_half  = half && (i == n - 1);
            in_data  = pw[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_half = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11", "hdr_done", 64'(hdr_done), 0);
        chk("R11", "pkt_done", 64'(pkt_done), 0);
        chk("R11", "pl_valid", 64'(pl_valid), 0);
        chk("R11", "src_addr", 64'(src_addr), 0);
        chk("R11", "hops_val", 64'(hops_val), 0);
    endtask

    task automatic t_src_dst();
        clear_mon();
        pw[0] = mk(3, 1, 1, 5, 4, 1); pw[1] = 16'h1234; pw[2] = 16'h0042;
        pw[3] = 16'hA1B2; pw[4] = 16'hC3D4;
        send(5, 1, 1, 0);
        chk("R1", "hops", c_hops, 3);   chk("R1", "dir", c_dir, 1);
        chk("R1", "am", c_am, 1);       chk("R1", "seq", c_seq, 5);
        chk("R1", "code", c_code, 4);   chk("R1", "layer", c_t, 1);
        chk("R2", "src", c_src, 64'h1234); chk("R2", "dst", c_dst, 64'h42);
        chk("R3", "hw absent", c_hw, 0); chk("R3", "hw flag", c_hp, 0);
        chk("R6", "payload words", 64'(pl_cnt), 2);
        chk("R6", "word0", 64'(pl_buf[0]), 64'hA1B2);
        chk("R6", "word1", 64'(pl_buf[1]), 64'hC3D4);
        chk("R7", "bytes", c_bytes, 4); chk("R7", "pkts", 64'(pkt_cnt), 1);
        chk("R5", "one hdr_done", 64'(hdr_cnt), 1);
        repeat (4) @(negedge clk);
        chk("R5", "src held", 64'(src_addr), 64'h1234);
    endtask

    task automatic t_src_only_odd();
        clear_mon();
        pw[0] = mk(0, 0, 0, 9, 2, 0); pw[1] = 16'h0BEE; pw[2] = 16'h1111; pw[3] = 16'h2200;
        send(4, 1, 1, 1);
        chk("R3", "dst default", c_dst, 0); chk("R3", "dst flag", c_dp, 0);
        chk("R2", "src", c_src, 64'h0BEE);
        chk("R6", "half flag", c_half, 1);
        chk("R7", "odd bytes", c_bytes, 3);
    endtask

    task automatic t_dst_only();
        clear_mon();
        pw[0] = mk(7, 0, 2, 1, 6, 1); pw[1] = 16'h0099; pw[2] = 16'h5555;
        send(3, 1, 1, 0);
        chk("R3", "src default", c_src, 0); chk("R3", "src flag", c_sp, 0);
        chk("R2", "dst", c_dst, 64'h99);    chk("R7", "bytes", c_bytes, 2);
    endtask

    task automatic t_hw_ext();
        clear_mon();
        pw[0] = mk(31, 1, 3, 2, 7, 0); pw[1] = 16'h0010; pw[2] = 16'h0321;
        pw[3] = 16'hAABB; pw[4] = 16'hCCDD; pw[5] = 16'hEEFF; pw[6] = 16'h0004;
        pw[7] = 16'h7777;
        send(8, 1, 1, 0);
        chk("R4", "hops ext", c_hops, 47); chk("R4", "ext flag", c_ep, 1);
        chk("R2", "dst", c_dst, 64'h0321);
        chk("R2", "hw", c_hw, 64'hAABBCCDDEEFF);
        chk("R2", "depth", c_dep, 4); chk("R3", "src default", c_src, 0);
        chk("R3", "hw flag", c_hp, 1);
        chk("R6", "payload words", 64'(pl_cnt), 1);
        chk("R6", "word0", 64'(pl_buf[0]), 64'h7777);
        chk("R7", "bytes", c_bytes, 2);
    endtask

    task automatic t_no_payload();
        clear_mon();
        pw[0] = mk(1, 0, 1, 3, 0, 0); pw[1] = 16'h0005; pw[2] = 16'h0006;
        send(3, 1, 1, 0);
        chk("R7", "hdr_done", 64'(hdr_cnt), 1); chk("R7", "pkt_done", 64'(pkt_cnt), 1);
        chk("R7", "zero bytes", c_bytes, 0); chk("R6", "no payload", 64'(pl_cnt), 0);
        chk("R8", "no trunc", c_tr, 0);
    endtask

    task automatic t_trunc();
        clear_mon();
        pw[0] = mk(2, 0, 3, 0, 1, 0); pw[1] = 16'h0123; pw[2] = 16'hAAAA;
        send(3, 1, 1, 0);
        chk("R8", "trunc mid", c_tr, 1); chk("R8", "no hdr_done", 64'(hdr_cnt), 0);
        chk("R8", "pkt_done", 64'(pkt_cnt), 1); chk("R8", "no payload", 64'(pl_cnt), 0);
        clear_mon();
        pw[0] = mk(2, 0, 1, 0, 1, 0);
        send(1, 1, 1, 0);
        chk("R8", "trunc base", c_tr, 1); chk("R8", "no hdr_done base", 64'(hdr_cnt), 0);
    endtask

    task automatic t_oversize();
        clear_mon();
        pw[0] = mk(0, 0, 2, 0, 0, 0); pw[1] = 16'h0001;
        for (int i = 0; i < 8; i++) pw[2+i] = 16'(i);
        send(10, 1, 1, 0);
        chk("R9", "at limit bytes", c_bytes, MAXP); chk("R9", "at limit err", c_ov, 0);
        clear_mon();
        for (int i = 0; i < 9; i++) pw[2+i] = 16'(i);
        send(11, 1, 1, 0);
        chk("R9", "over err", c_ov, 1); chk("R9", "saturated", c_bytes, MAXP + 1);
    endtask

    task automatic t_restart();
        clear_mon();
        pw[0] = mk(4, 0, 3, 0, 0, 0); pw[1] = 16'h0AAA;
        send(2, 1, 0, 0);
        pw[0] = mk(5, 1, 2, 8, 3, 1); pw[1] = 16'h0077; pw[2] = 16'hBC00;
        send(3, 1, 1, 1);
        chk("R10", "hdr_done", 64'(hdr_cnt), 1); chk("R10", "dst", c_dst, 64'h77);
        chk("R10", "hw cleared", c_hw, 0); chk("R10", "bytes", c_bytes, 1);
        chk("R10", "no trunc", c_tr, 0);
        clear_mon();
        pw[0] = 16'h1234; pw[1] = 16'h5678;
        send(2, 0, 1, 0);
        chk("R10", "stray payload", 64'(pl_cnt), 0);
        chk("R10", "stray pkt", 64'(pkt_cnt), 0);
        chk("R10", "stray hdr", 64'(hdr_cnt), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_src_dst();
        t_src_only_odd();
        t_dst_only();
        t_hw_ext();
        t_no_payload();
        t_trunc();
        t_oversize();
        t_restart();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule